// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a watchdog timer with a programmable time-out. The time-out is written as two packed-BCD bytes: one holds whole seconds and the other holds hundredths of a second, so the longest time-out is 99.99 s. A one-clock tick pulse at 100 Hz drives the countdown. Software keeps the system alive by rewriting either count byte before the countdown runs out. Each such write reloads the full programmed period.

When the countdown expires, the block sets a sticky expiry flag and reloads itself. A steering bit in the control register selects the action taken at expiry. With the bit set, a reset pulse of fixed length is sent out. With the bit clear, the interrupt line stays asserted for as long as the flag is set. Reading the status register clears the flag.

All registers are reached through a byte-wide port with a 2-bit address. Reads are combinational.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset, every register reads 0x00, and `wdogRst` and `wdogIrq` are low.
- R2: Address map and read-back:
  - Address 0 holds the hundredths byte. Address 1 holds the seconds byte. Both are packed BCD with the tens digit in bits 7:4, and both read back exactly as written.
  - Address 3 is control: bit 0 enables the timer, and bit 1 steers expiry to the reset output. Unused bits read 0.
  - Address 2 is status: bit 0 is the expiry flag, and all other bits read 0.
- R3: The timer runs when it is enabled and the programmed value is non-zero. Take the programmed value as SS.HH. Expiry happens at the clock edge that samples the (SS*100+HH)-th tick after the last reload. The count decrements in BCD, so hundredths borrow from seconds when they roll under 00.
- R4: A write to address 0 or address 1 reloads the countdown from the full new programmed value. A tick sampled in the same cycle as such a write is ignored and cannot cause expiry.
- R5: Expiry sets the status flag. A read of address 2 clears the flag at that clock edge. If expiry and the read fall in the same cycle, the flag stays set.
- R6: With steer set, expiry drives `wdogRst` high for exactly RST_CYCLES clocks, starting the cycle after the expiry edge. `wdogIrq` stays low in this mode.
- R7: With steer clear, `wdogIrq` equals the status flag, and no reset pulse is started.
- R8: While the timer is disabled, or while the programmed value is 00.00, ticks have no effect. The count is held at the programmed value, so enabling the timer starts a full period.
- R9: At expiry the countdown reloads the programmed value, so a timer that is not kicked expires again once every period.
- R10: Writes to address 2 have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse every 10 ms |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (clears the flag when address is 2) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `addr` |
| wdogRst | output | 1 | Reset pulse at expiry when steer is set |
| wdogIrq | output | 1 | Interrupt level when steer is clear |

## Verification
The assertions check several rules on every cycle:
- No reset pulse starts, and the interrupt does not rise, unless a tick arrived in the cycle before. The interrupt may also rise after a control write.
- A count write is never followed by an expiry.
- A status read with no tick leaves the interrupt low.
- Both outputs are quiet when reset is released.

Some behaviour only the bench's scenarios can show:
- The exact number of ticks to expiry, including the BCD borrow across the byte boundary.
- The periodic reload.
- The exact reset pulse length.
- That a disabled timer or a zero value holds off expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] ADDR_FRAC   = 2'd0;
  localparam logic [1:0] ADDR_SEC    = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  typedef struct packed {
    logic load;
    logic dec;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        strb,
  input  logic [4*NDIG-1:0] loadVal,
  output logic              lastTick
);
  localparam int CW = 4 * NDIG;

  logic [CW-1:0]   cnt;
  logic [CW-1:0]   decVal;
  logic [NDIG-1:0] borrow;

  assign borrow[0] = 1'b1;

  // BCD decrement, one digit per iteration, borrow rippling upward
  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
      logic [3:0] dIn;
      logic [3:0] dOut;
      assign dIn = cnt[4*g +: 4];
      always_comb begin
        if (!borrow[g])       dOut = dIn;
        else if (dIn == 4'd0) dOut = 4'd9;
        else                  dOut = dIn - 4'd1;
      end
      assign decVal[4*g +: 4] = dOut;
      if (g < NDIG - 1) begin : g_borrow
        assign borrow[g+1] = borrow[g] && (dIn == 4'd0);
      end
    end
  endgenerate

  assign lastTick = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (strb.load) cnt <= loadVal;
    else if (strb.dec)  cnt <= decVal;
  end
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [1:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  input  logic        lastTick,
  output wdtStrobe_t  strb,
  output logic [15:0] loadVal,
  output logic [7:0]  rdData,
  output logic        wdogRst,
  output logic        wdogIrq
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [7:0]    progFrac, progSec;
  logic          cfgEn, cfgSteer, expFlag;
  logic [RW-1:0] rstLeft;
  logic          wrFrac, wrSec, countWrite, running, expire;

  always_comb begin
    wrFrac     = wrEn && (addr == ADDR_FRAC);
    wrSec      = wrEn && (addr == ADDR_SEC);
    countWrite = wrFrac || wrSec;
    loadVal    = {wrSec ? wrData : progSec, wrFrac ? wrData : progFrac};
    running    = cfgEn && ({progSec, progFrac} != 16'd0);
    expire     = tick && running && lastTick && !countWrite;
    strb.load  = countWrite || !running || expire;
    strb.dec   = tick && running && !lastTick && !countWrite;
  end

  always_comb begin
    case (addr)
      ADDR_FRAC:   rdData = progFrac;
      ADDR_SEC:    rdData = progSec;
      ADDR_STATUS: rdData = {7'd0, expFlag};
      default:     rdData = {6'd0, cfgSteer, cfgEn};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progFrac <= '0;
      progSec  <= '0;
      cfgEn    <= 1'b0;
      cfgSteer <= 1'b0;
    end else begin
      if (wrFrac) progFrac <= wrData;
      if (wrSec)  progSec  <= wrData;
      if (wrEn && addr == ADDR_CTRL) begin
        cfgEn    <= wrData[0];
        cfgSteer <= wrData[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                expFlag <= 1'b0;
    else if (expire)                          expFlag <= 1'b1;
    else if (rdEn && addr == ADDR_STATUS)     expFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  rstLeft <= '0;
    else if (expire && cfgSteer) rstLeft <= RW'(RST_CYCLES);
    else if (rstLeft != '0)     rstLeft <= rstLeft - RW'(1);
  end

  assign wdogRst = (rstLeft != '0);
  assign wdogIrq = expFlag && !cfgSteer;
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
  import wdt_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       wdogRst,
  output logic       wdogIrq
);
  wdtStrobe_t  strb;
  logic [15:0] loadVal;
  logic        lastTick;

  wdt_control #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .lastTick(lastTick), .strb(strb),
    .loadVal(loadVal), .rdData(rdData), .wdogRst(wdogRst), .wdogIrq(wdogIrq)
  );

  wdt_datapath #(.NDIG(4)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .lastTick(lastTick)
  );
endmodule

// File: rtl/bcd_watchdog_checker.sv
module bcd_watchdog_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic [1:0] addr,
  input logic       wrEn,
  input logic       rdEn,
  input logic       wdogRst,
  input logic       wdogIrq
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!wdogRst && !wdogIrq));

  p_rst_after_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogRst) |-> $past(tick));

  // R7: interrupt rises after an expiry tick or a control write (steer change)
  p_irq_after_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogIrq) |-> ($past(tick) || $past(wrEn && addr == 2'd3)));

  p_kick_no_rst_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == 2'd0 || addr == 2'd1)) |=> !$rose(wdogRst));

  p_kick_no_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == 2'd0 || addr == 2'd1)) |=> !$rose(wdogIrq));

  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd2 && !tick) |=> !wdogIrq);
endmodule

bind bcd_watchdog bcd_watchdog_checker chk (
  .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
  .rdEn(rdEn), .wdogRst(wdogRst), .wdogIrq(wdogIrq)
);

// File: tb/bcd_watchdog_test.sv
module bcd_watchdog_test;
  localparam int RSTC = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       wdogRst, wdogIrq;

  int nChecks = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  bcd_watchdog #(.RST_CYCLES(RSTC)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .wdogRst(wdogRst), .wdogIrq(wdogIrq)
  );

  // ---------------- reference model ----------------
  int  mFrac = 0, mSec = 0, mEn = 0, mSteer = 0, mFlag = 0;
  int  mCount = 0, mRstLeft = 0;
  int  nf, ns;
  bit  cw, run, expd, live = 0;
  int  pulseRun = 0, lastPulse = 0;

  function automatic int bcdVal(input int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  always @(posedge clk) begin
    live <= 1'b1;
    if (!rstN) begin
      mFrac = 0; mSec = 0; mEn = 0; mSteer = 0; mFlag = 0;
      mCount = 0; mRstLeft = 0;
    end else begin
      nf = (wrEn && addr == 2'd0) ? int'(wrData) : mFrac;
      ns = (wrEn && addr == 2'd1) ? int'(wrData) : mSec;
      cw = wrEn && (addr == 2'd0 || addr == 2'd1);
      run = (mEn != 0) && (mFrac != 0 || mSec != 0);
      expd = tick && run && (mCount == 1) && !cw;
      if (cw || !run || expd) mCount = bcdVal(ns) * 100 + bcdVal(nf);
      else if (tick)          mCount = mCount - 1;
      if (expd)                            mFlag = 1;
      else if (rdEn && addr == 2'd2)       mFlag = 0;
      if (expd && mSteer != 0)             mRstLeft = RSTC;
      else if (mRstLeft > 0)               mRstLeft = mRstLeft - 1;
      if (wrEn && addr == 2'd3) begin
        mEn = int'(wrData[0]);
        mSteer = int'(wrData[1]);
      end
      mFrac = nf;
      mSec = ns;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRd(input logic [1:0] a);
    case (a)
      2'd0: return mFrac;
      2'd1: return mSec;
      2'd2: return mFlag;
      default: return mSteer * 2 + mEn;
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk("R2 rdData", int'(rdData), expRd(addr));
      chk("R6 wdogRst", int'(wdogRst), (mRstLeft > 0) ? 1 : 0);
      chk("R7 wdogIrq", int'(wdogIrq), (mFlag != 0 && mSteer == 0) ? 1 : 0);
      if (wdogRst) pulseRun++;
      else begin
        if (pulseRun != 0) lastPulse = pulseRun;
        pulseRun = 0;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    addr = a; wrEn = 1'b1; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a);
    @(posedge clk); #2;
    addr = a; rdEn = 1'b1;
    @(posedge clk); #2;
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; tick = 1'b1;
      @(posedge clk); #2; tick = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // sample the read port at a given address away from the edge
  task automatic peek(input logic [1:0] a, input string tag, input int exp);
    @(posedge clk); #2; addr = a;
    @(negedge clk);
    chk(tag, int'(rdData), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    idle(3);
    @(posedge clk); #2 rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) peek(2'(a), "R1 reset register", 0);
    @(negedge clk);
    chk("R1 reset wdogRst", int'(wdogRst), 0);
    chk("R1 reset wdogIrq", int'(wdogIrq), 0);

    // R2 register readback
    writeReg(2'd0, 8'h05);
    writeReg(2'd1, 8'h00);
    writeReg(2'd3, 8'h01);
    peek(2'd0, "R2 hundredths readback", 8'h05);
    peek(2'd3, "R2 control readback", 1);

    // R3 expiry on the 5th tick
    ticks(4);
    @(negedge clk); chk("R3 no expiry after 4 ticks", int'(wdogIrq), 0);
    ticks(1);
    @(negedge clk); chk("R3 expiry on 5th tick", int'(wdogIrq), 1);
    peek(2'd2, "R5 flag set", 1);

    // R5 read clears
    readReg(2'd2);
    @(negedge clk); chk("R5 flag cleared by read", int'(wdogIrq), 0);

    // R9 periodic re-expiry
    ticks(5);
    @(negedge clk); chk("R9 periodic expiry", int'(wdogIrq), 1);
    readReg(2'd2);

    // R4 kick reloads full period
    ticks(3);
    writeReg(2'd0, 8'h05);
    ticks(4);
    @(negedge clk); chk("R4 kick postpones expiry", int'(wdogIrq), 0);
    ticks(1);
    @(negedge clk); chk("R4 expiry after full period", int'(wdogIrq), 1);
    readReg(2'd2);

    // R4 write in same cycle as tick: tick ignored
    ticks(2);
    @(posedge clk); #2;
    addr = 2'd0; wrEn = 1'b1; wrData = 8'h05; tick = 1'b1;
    @(posedge clk); #2; wrEn = 1'b0; tick = 1'b0;
    ticks(4);
    @(negedge clk); chk("R4 tick with write ignored", int'(wdogIrq), 0);
    ticks(1);
    @(negedge clk); chk("R4 expiry after kick-with-tick", int'(wdogIrq), 1);
    readReg(2'd2);

    // R3 BCD borrow: 01.02 is 102 ticks
    writeReg(2'd1, 8'h01);
    writeReg(2'd0, 8'h02);
    ticks(101);
    @(negedge clk); chk("R3 borrow no early expiry", int'(wdogIrq), 0);
    ticks(1);
    @(negedge clk); chk("R3 borrow expiry at 102", int'(wdogIrq), 1);
    readReg(2'd2);

    // R6 steer to reset
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, 8'h03);
    writeReg(2'd3, 8'h03);
    ticks(3);
    idle(RSTC + 4);
    @(negedge clk);
    chk("R6 reset pulse length", lastPulse, RSTC);
    chk("R6 irq low while steered", int'(wdogIrq), 0);
    peek(2'd2, "R5 flag set in reset mode", 1);
    readReg(2'd2);

    // R8 disabled: no expiry, full period on re-enable
    writeReg(2'd3, 8'h00);
    ticks(6);
    peek(2'd2, "R8 disabled no expiry", 0);
    writeReg(2'd3, 8'h01);
    ticks(2);
    @(negedge clk); chk("R8 re-enable full period", int'(wdogIrq), 0);
    ticks(1);
    @(negedge clk); chk("R8 expiry after re-enable", int'(wdogIrq), 1);
    readReg(2'd2);

    // R8 zero value holds idle while enabled
    writeReg(2'd0, 8'h00);
    ticks(6);
    peek(2'd2, "R8 zero value idle", 0);

    // R10 status write ignored, and R5 set wins over clear
    writeReg(2'd2, 8'hFF);
    peek(2'd2, "R10 status write ignored", 0);
    writeReg(2'd0, 8'h01);
    @(posedge clk); #2;
    addr = 2'd2; rdEn = 1'b1; tick = 1'b1;
    @(posedge clk); #2; rdEn = 1'b0; tick = 1'b0;
    @(negedge clk); chk("R5 set wins over read clear", int'(rdData), 1);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule